// File: doc/BRIEF.md
# Fracturable Six/Seven-Input Logic Cell

This block is a soft model of one programmable logic cell. It has eight data inputs, two output registers and a bank of configuration bits. The configuration is shifted in one bit per clock over a two-wire serial port. After loading, the cell evaluates a lookup-table function in one of two modes.

In normal mode, a six-input function is built from four shared inputs plus one of two input pairs. The function drives the top path when the first pair is chosen and the bottom path when the second pair is chosen. In extended mode, the cell picks one of two five-input tables with a select input, which gives a seven-input function on the top path. Each path can expose its result combinationally, capture it in its register, or do both. An input the function leaves free can instead be loaded straight into a register.

A three-state controller sequences the cell:
- **ST_BLANK** is entered at reset. The cell is unconfigured and its outputs are zero.
- **ST_LOAD** is entered whenever `cfg_en` is sampled high. The configuration shifts in and the outputs are held at zero.
- **ST_RUN** is entered from ST_LOAD when `cfg_en` is sampled low. The cell evaluates its function.

The transitions are: BLANK→LOAD and RUN→LOAD on `cfg_en`=1, LOAD→RUN on `cfg_en`=0, BLANK→BLANK and RUN→RUN otherwise, and LOAD→LOAD while `cfg_en` stays high.

Top module: `frac_lcell`

## Requirements
- R1: Reset is active-low and synchronous. It clears both registers and the whole configuration, and it enters ST_BLANK. In ST_BLANK all four outputs stay 0, whatever `din` does.
- R2: On each clock edge where `cfg_en` is high, `cfg_din` shifts into the 70-bit configuration word, most significant bit first. The field positions are:
  - bit 69: mode (0 = normal, 1 = extended)
  - bit 68: pair select (0 = pair e0/f0, 1 = pair e1/f1)
  - bit 67: top register takes the function
  - bit 66: bottom register takes the function
  - bit 65: top combinational enable
  - bit 64: bottom combinational enable
  - bits 63:32: table B
  - bits 31:0: table A
- R3: From the edge where `cfg_en` is sampled high until the edge where it is sampled low, all four outputs read 0. Both registers are cleared at the first of those edges.
- R4: The `din` bits map as follows: bit 0 = a, bit 1 = b, bit 2 = c, bit 3 = d, bit 4 = e0, bit 5 = f0, bit 6 = e1, bit 7 = f1. In normal mode with pair select 0, the function is entry {f0,e0,d,c,b,a} of the 64-bit table {B,A}, where a is the index LSB and indexes 0–31 fall in A. `top_comb` shows this function when the top enable is set, and `bot_comb` is 0.
- R5: In normal mode with pair select 1, the function is entry {f1,e1,d,c,b,a} of {B,A}. `bot_comb` shows it when the bottom enable is set, and `top_comb` is 0.
- R6: In extended mode, the result is B[{e1,d,c,b,a}] when f0=1 and A[{e0,d,c,b,a}] when f0=0. `top_comb` shows this result when the top enable is set.
- R7: In ST_RUN, with `cfg_en` low, each edge loads both registers. The top register takes the function when bit 67 is set and the function is on the top path (normal pair 0 or extended). `top_q` and `bot_q` show the top and bottom registers.
- R8: When the top path's function is not registered, the top register packs a free input instead:
  - e1 in normal mode with pair 0
  - f1 in extended mode
  - e0 in normal mode with pair 1
- R9: The bottom register loads as follows:
  - Normal mode with pair 1: the function when bit 66 is set, otherwise f0.
  - Normal mode with pair 0: f1 when bit 67 is clear, otherwise 0.
- R10: In extended mode the bottom register and `bot_comb` are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data, MSB first |
| din | input | 8 | Cell data inputs a,b,c,d,e0,f0,e1,f1 (bit 0 upward) |
| top_comb | output | 1 | Top path combinational result |
| bot_comb | output | 1 | Bottom path combinational result |
| top_q | output | 1 | Top register |
| bot_q | output | 1 | Bottom register |

## Verification
A controller stuck in the wrong state produces one of two symptoms. If it is stuck in load or blank, the outputs are zero where the reference expects a function value. If it is stuck in run, nonzero outputs appear one edge after `cfg_en` rises. A misaligned configuration word corrupts table entries or routing flags, and the first exhaustive sweep of 256 input patterns exposes it at `top_comb`/`bot_comb` in the same cycle. A wrong register source shows at `top_q`/`bot_q` one edge later. The bench runs several configurations covering both pair selects, extended mode, each packing source and the blocked bottom register, and each is swept exhaustively.

// File: rtl/flc_pkg.sv
package flc_pkg;

    typedef enum logic [1:0] {
        ST_BLANK = 2'd0,
        ST_LOAD  = 2'd1,
        ST_RUN   = 2'd2
    } cell_state_t;

    // Routing flags, MSB first as shifted in
    typedef struct packed {
        logic mode;     // 1 = extended
        logic psel;     // 1 = function uses e1/f1
        logic r0_fn;    // top register takes function
        logic r1_fn;    // bottom register takes function
        logic byp0;     // top combinational enable
        logic byp1;     // bottom combinational enable
    } cell_flags_t;

    localparam int FLAG_W = $bits(cell_flags_t);

endpackage

// File: rtl/flc_cfg_shift.sv
module flc_cfg_shift #(
    parameter int W = 70
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         sin,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (shift_en) begin
            word <= {word[W-2:0], sin};
        end
    end
endmodule

// File: rtl/flc_fsm.sv
module flc_fsm
    import flc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_en,
    output logic run,
    output logic upd
);
    cell_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_BLANK;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_BLANK: state_nx = cfg_en ? ST_LOAD : ST_BLANK;
            ST_LOAD:  state_nx = cfg_en ? ST_LOAD : ST_RUN;
            ST_RUN:   state_nx = cfg_en ? ST_LOAD : ST_RUN;
            default:  state_nx = ST_BLANK;
        endcase
    end

    always_comb begin
        run = 1'b0;
        upd = 1'b0;
        unique case (state)
            ST_BLANK: run = 1'b0;
            ST_LOAD:  run = 1'b0;
            ST_RUN: begin
                run = 1'b1;
                upd = !cfg_en;
            end
            default:  run = 1'b0;
        endcase
    end
endmodule

// File: rtl/flc_core.sv
module flc_core
    import flc_pkg::*;
#(
    parameter int LUT_K = 5
) (
    input  logic [(1<<LUT_K)-1:0] tbl_a,
    input  logic [(1<<LUT_K)-1:0] tbl_b,
    input  cell_flags_t           flg,
    input  logic [LUT_K+2:0]      din,
    output logic                  top_f,
    output logic                  bot_f,
    output logic                  d0,
    output logic                  d1
);
    localparam int N_SH = LUT_K - 1;
    localparam int P_E0 = N_SH;
    localparam int P_F0 = N_SH + 1;
    localparam int P_E1 = N_SH + 2;
    localparam int P_F1 = N_SH + 3;

    logic [N_SH-1:0] sh;
    logic            e0, f0, e1, f1;
    logic [1:0]      pair;
    logic            fn_norm, fa, fb, fn_ext;

    assign sh = din[N_SH-1:0];
    assign e0 = din[P_E0];
    assign f0 = din[P_F0];
    assign e1 = din[P_E1];
    assign f1 = din[P_F1];

    // Normal mode: high pair bit chooses the table half
    assign pair    = flg.psel ? {f1, e1} : {f0, e0};
    assign fn_norm = pair[1] ? tbl_b[{pair[0], sh}] : tbl_a[{pair[0], sh}];

    // Extended mode: two five-input tables, f0 selects
    assign fa     = tbl_a[{e0, sh}];
    assign fb     = tbl_b[{e1, sh}];
    assign fn_ext = f0 ? fb : fa;

    always_comb begin
        top_f = 1'b0;
        bot_f = 1'b0;
        d0    = 1'b0;
        d1    = 1'b0;
        if (flg.mode) begin
            top_f = flg.byp0 & fn_ext;
            d0    = flg.r0_fn ? fn_ext : f1;
        end else if (!flg.psel) begin
            top_f = flg.byp0 & fn_norm;
            d0    = flg.r0_fn ? fn_norm : e1;
            d1    = flg.r0_fn ? 1'b0 : f1;
        end else begin
            bot_f = flg.byp1 & fn_norm;
            d0    = e0;
            d1    = flg.r1_fn ? fn_norm : f0;
        end
    end
endmodule

// File: rtl/frac_lcell.sv
module frac_lcell
    import flc_pkg::*;
#(
    parameter int LUT_K = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_din,
    input  logic [LUT_K+2:0] din,
    output logic             top_comb,
    output logic             bot_comb,
    output logic             top_q,
    output logic             bot_q
);
    localparam int TBL   = 1 << LUT_K;
    localparam int CFG_W = 2 * TBL + FLAG_W;

    logic [CFG_W-1:0] cfg_word;
    logic [TBL-1:0]   tbl_a, tbl_b;
    cell_flags_t      flg;
    logic             run, upd;
    logic             top_f, bot_f, d0, d1;
    logic             q0, q1;

    flc_cfg_shift #(.W(CFG_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_en),
        .sin      (cfg_din),
        .word     (cfg_word)
    );

    assign tbl_a = cfg_word[TBL-1:0];
    assign tbl_b = cfg_word[2*TBL-1:TBL];
    assign flg   = cell_flags_t'(cfg_word[CFG_W-1:2*TBL]);

    flc_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_en (cfg_en),
        .run    (run),
        .upd    (upd)
    );

    flc_core #(.LUT_K(LUT_K)) u_core (
        .tbl_a (tbl_a),
        .tbl_b (tbl_b),
        .flg   (flg),
        .din   (din),
        .top_f (top_f),
        .bot_f (bot_f),
        .d0    (d0),
        .d1    (d1)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q0 <= 1'b0;
            q1 <= 1'b0;
        end else if (upd) begin
            q0 <= d0;
            q1 <= d1;
        end else begin
            q0 <= 1'b0;
            q1 <= 1'b0;
        end
    end

    assign top_comb = run & top_f;
    assign bot_comb = run & bot_f;
    assign top_q    = q0;
    assign bot_q    = q1;
endmodule

// File: rtl/flc_check.sv
module flc_check
    import flc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_en,
    input logic        run,
    input cell_flags_t flg,
    input logic        top_comb,
    input logic        bot_comb,
    input logic        top_q,
    input logic        bot_q
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (top_q == 1'b0 && bot_q == 1'b0));

    a_r3_quiet_in_load: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (top_comb == 1'b0 && bot_comb == 1'b0 && top_q == 1'b0 && bot_q == 1'b0));

    a_r4_pair0_top_only: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !flg.mode && !flg.psel) |-> (bot_comb == 1'b0));

    a_r5_pair1_bottom_only: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !flg.mode && flg.psel) |-> (top_comb == 1'b0));

    a_r7_reg_follows_comb: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cfg_en && flg.r0_fn && flg.byp0 && (flg.mode || !flg.psel))
        |=> (top_q == $past(top_comb)));

    a_r9_f1_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cfg_en && !flg.mode && !flg.psel && flg.r0_fn) |=> (bot_q == 1'b0));

    a_r10_ext_bottom_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (run && flg.mode) |-> (bot_comb == 1'b0 && bot_q == 1'b0));
endmodule

bind frac_lcell flc_check u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .run      (run),
    .flg      (flg),
    .top_comb (top_comb),
    .bot_comb (bot_comb),
    .top_q    (top_q),
    .bot_q    (bot_q)
);

// File: tb/frac_lcell_test.sv
module frac_lcell_test;
    localparam int CLK_P  = 10;
    localparam int N_CFG  = 8;

    // {mode, psel, r0_fn, r1_fn, byp0, byp1, tableB, tableA}
    localparam logic [69:0] CFG_TAB [N_CFG] = '{
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'hDEADBEEF, 32'h0F1E2D3C},
        {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h80000001, 32'h12345678},
        {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 32'hC3A5965A, 32'h7E81BD42},
        {1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0000FFFF, 32'hF0F0F0F0},
        {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 32'hCAFEBABE, 32'h13579BDF},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h6996C33C, 32'h55AA00FF},
        {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h2468ACE0, 32'hFDB97531},
        {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'hAAAA5555, 32'h0000FFFF}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic [7:0] din = 8'h00;
    logic       top_comb, bot_comb, top_q, bot_q;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    frac_lcell uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .din      (din),
        .top_comb (top_comb),
        .bot_comb (bot_comb),
        .top_q    (top_q),
        .bot_q    (bot_q)
    );

    // Reference model from the requirements: {top_comb, bot_comb, next top_q, next bot_q}
    function automatic logic [3:0] model(input logic [69:0] w, input logic [7:0] x);
        logic [63:0] full;
        logic [31:0] ta, tb;
        logic fn, tc, bc, n0, n1;
        int idx;
        ta = w[31:0];
        tb = w[63:32];
        full = {tb, ta};
        tc = 0; bc = 0; n0 = 0; n1 = 0;
        if (w[69]) begin
            fn = x[5] ? tb[{x[6], x[3:0]}] : ta[{x[4], x[3:0]}];
            tc = w[65] & fn;
            n0 = w[67] ? fn : x[7];
        end else if (!w[68]) begin
            idx = int'(x[5:0]);
            fn  = full[idx];
            tc  = w[65] & fn;
            n0  = w[67] ? fn : x[6];
            n1  = w[67] ? 1'b0 : x[7];
        end else begin
            idx = int'({x[7], x[6], x[3:0]});
            fn  = full[idx];
            bc  = w[64] & fn;
            n0  = x[4];
            n1  = w[66] ? fn : x[5];
        end
        return {tc, bc, n0, n1};
    endfunction

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b (t=%0t)", tag, got, exp, $time);
        end
    endtask

    task automatic finish_up;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // R2: shift 70 bits MSB first; R3: outputs silent mid-load
    task automatic load_cfg(input logic [69:0] w);
        @(negedge clk);
        din    = 8'hFF;
        cfg_en = 1'b1;
        for (int i = 69; i >= 0; i--) begin
            cfg_din = w[i];
            @(negedge clk);
            if (i == 35) chk("R3 outputs during load", {top_comb, bot_comb, top_q, bot_q}, 4'b0000);
        end
        cfg_en  = 1'b0;
        cfg_din = 1'b0;
    endtask

    task automatic sweep(input logic [69:0] w, input string tag);
        logic [3:0] e;
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            din = v[7:0];
            e = model(w, din);
            #1;
            chk({tag, " comb"}, {2'b00, top_comb, bot_comb}, {2'b00, e[3:2]});
            @(posedge clk);
            #1;
            chk({tag, " reg"}, {2'b00, top_q, bot_q}, {2'b00, e[1:0]});
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hung expected finish");
            finish_up();
        end
    end

    initial begin
        string tag;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 during reset", {top_comb, bot_comb, top_q, bot_q}, 4'b0000);
        rst_n = 1'b1;
        // R1: blank cell ignores inputs
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            din = 8'hFF ^ k[7:0];
            #1;
            chk("R1 blank after reset", {top_comb, bot_comb, top_q, bot_q}, 4'b0000);
        end

        // Table walk: each configuration swept exhaustively
        for (int c = 0; c < N_CFG; c++) begin
            if (CFG_TAB[c][69])      tag = "R6/R7/R8/R10 extended";
            else if (CFG_TAB[c][68]) tag = "R5/R8/R9 pair1";
            else                     tag = "R4/R7/R8/R9 pair0";
            load_cfg(CFG_TAB[c]);
            sweep(CFG_TAB[c], tag);
        end

        // R3: raising cfg_en in run silences outputs at the next edge
        load_cfg(CFG_TAB[0]);
        @(negedge clk);
        din = 8'h3F;   // table entry 63 = B bit 31 = 1 in config 0
        @(negedge clk);
        #1;
        chk("R3 run before reload", {top_comb, bot_comb, top_q, bot_q}, 4'b1010);
        cfg_en = 1'b1;
        @(posedge clk);
        #1;
        chk("R3 first load edge", {top_comb, bot_comb, top_q, bot_q}, 4'b0000);
        @(negedge clk);
        cfg_en = 1'b0;
        @(posedge clk);
        #1;
        chk("R3 load ended, regs cleared", {top_q, bot_q, 2'b00}, 4'b0000);

        // R1: mid-run reset clears registers and config
        load_cfg(CFG_TAB[0]);
        @(negedge clk);
        din = 8'h3F;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset in run", {top_comb, bot_comb, top_q, bot_q}, 4'b0000);
        repeat (2) @(negedge clk);
        #1;
        chk("R1 blank after run reset", {top_comb, bot_comb, top_q, bot_q}, 4'b0000);

        done = 1'b1;
        finish_up();
    end
endmodule